// File: doc/BRIEF.md
# Spectrum-to-LED Color Mapper

This block converts the magnitudes of the lowest frequency bins of an audio transform into one 24-bit color for each LED of a 30-LED strip. A transform stage streams its magnitudes out in bin order. The block keeps the first 30 of them in a shadow bank. When the last of those bins arrives, the whole set is copied into a display bank in a single cycle. A 1024-point transform of 48 kHz audio gives bins about 47 Hz wide, so the strip covers roughly 47 Hz to 1.4 kHz.

Each LED has a fixed hue. The hues run from red on LED 0, which is the lowest bin, to violet on LED 29. In spectrum mode the brightness of LED n follows the stored magnitude of bin n after a gain picked by a 3-bit sensitivity code. A 2-bit mode input can replace the spectrum with a static rainbow or with solid yellow. A downstream serializer reads the colors by LED index and gets each one a cycle later.

The magnitude input is a valid/ready stream. Ready is always high, so the block never applies back-pressure: every cycle with valid high transfers one magnitude. A producer that stalls simply holds valid low. Index, sensitivity and mode are plain levels.

Top module: `spec_led_mapper`

## Requirements
- R1: `bin_ready_o` is high in every cycle after reset. A transfer with an index of 30 or more is dropped and changes no stored magnitude.
- R2: An accepted magnitude with an index below 30 goes into the shadow bank. The display bank, which alone feeds the colors, takes all 30 shadow values in the cycle that bin 29 is accepted, including the bin 29 value arriving in that cycle. Until then the colors keep showing the previous set.
- R3: `led_color_o` is registered. It reflects the `led_idx_i`, `mode_i`, `gain_i` and display bank sampled at the previous rising edge. It is packed green in [23:16], red in [15:8] and blue in [7:0].
- R4: The hue of LED n is defined as follows. Let p = (n*1275)/29, s = p/255 and t = p%255, all in integer arithmetic. The (red, green, blue) value is then (255,t,0) for s=0, (255-t,255,0) for s=1, (0,255,t) for s=2, (0,255-t,255) for s=3, (t/2,0,255) for s=4 and (127,0,255) for s=5. LED 0 is red {00,FF,00} and LED 29 is violet {00,7F,FF}.
- R5: The sensitivity level is L = min(255, m << g), where m is the stored magnitude and g is the code on `gain_i`. Code 0 is the least sensitive and code 7 the most.
- R6: In mode 00 (spectrum), each color component is (h*(L+1))>>8, where h is the matching hue component. A zero magnitude therefore gives black and L = 255 gives the full hue.
- R7: Modes 01 and 10 both show the full hue of R4 on every LED, whatever the stored magnitudes and the sensitivity.
- R8: Mode 11 shows yellow on every LED: `led_color_o` = 24'hFFFF00.
- R9: An LED index of 30 or 31 gives black (all zero) in every mode.
- R10: During reset `led_color_o` is zero, and both banks are cleared to zero magnitudes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_valid_i | input | 1 | Magnitude transfer valid |
| bin_ready_o | output | 1 | Always high: the block accepts every transfer |
| bin_idx_i | input | 10 | Frequency bin index of the transfer |
| bin_mag_i | input | 8 | Bin magnitude |
| gain_i | input | 3 | Sensitivity code (left-shift amount) |
| mode_i | input | 2 | 00 spectrum, 01/10 rainbow, 11 yellow |
| led_idx_i | input | 5 | LED whose color is read |
| led_color_o | output | 24 | {green, red, blue} of the LED addressed one cycle earlier |

## Verification
A slot written to the wrong bank, or a commit that fires early, shows in spectrum mode as one LED changing brightness before bin 29 has arrived. The bench reads every LED between the bin 28 and bin 29 writes and catches this at once. A wrong hue entry or a wrong saturation boundary shows on the next read of that LED at full or overdriven level, one cycle after its index is applied. Stray transfers with high indices would corrupt a slot, and that slot reads wrong the next time a frame is committed.

// File: rtl/spec_led_pkg.sv
package spec_led_pkg;

  localparam int COMP_W = 8;

  typedef struct packed {
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] b;
  } grb_t;

  typedef enum logic [1:0] {
    MODE_SPECTRUM = 2'b00,
    MODE_RAINBOW0 = 2'b01,
    MODE_RAINBOW1 = 2'b10,
    MODE_SOLID    = 2'b11
  } show_mode_e;

  // Fixed hue of one LED along the red-to-violet gradient.
  function automatic grb_t hue_at(input int n, input int leds);
    int   p;
    int   seg;
    int   t;
    grb_t c;
    p   = (leds > 1) ? (n * 1275) / (leds - 1) : 0;
    seg = p / 255;
    t   = p % 255;
    c   = '0;
    case (seg)
      0: begin c.r = 8'd255;          c.g = 8'(t);           c.b = 8'd0;   end
      1: begin c.r = 8'(255 - t);     c.g = 8'd255;          c.b = 8'd0;   end
      2: begin c.r = 8'd0;            c.g = 8'd255;          c.b = 8'(t);  end
      3: begin c.r = 8'd0;            c.g = 8'(255 - t);     c.b = 8'd255; end
      4: begin c.r = 8'(t / 2);       c.g = 8'd0;            c.b = 8'd255; end
      default: begin c.r = 8'd127;    c.g = 8'd0;            c.b = 8'd255; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spec_bin_store.sv
module spec_bin_store #(
  parameter int N_LEDS    = 30,
  parameter int MAG_W     = 8,
  parameter int IDX_W     = 10,
  parameter int LED_IDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [MAG_W-1:0]     wr_mag_i,
  input  logic [LED_IDX_W-1:0] rd_idx_i,
  output logic [MAG_W-1:0]     rd_mag_o,
  output logic                 commit_o
);

  localparam int                   SLOT_W  = $clog2(N_LEDS);
  localparam logic [IDX_W-1:0]     WR_LAST = IDX_W'(N_LEDS - 1);
  localparam logic [LED_IDX_W-1:0] RD_LAST = LED_IDX_W'(N_LEDS - 1);

  logic [MAG_W-1:0] shadow_q [N_LEDS];
  logic [MAG_W-1:0] disp_q   [N_LEDS];
  logic             wr_hit;
  logic [SLOT_W-1:0] wr_slot;

  assign wr_hit   = wr_en_i && (wr_idx_i <= WR_LAST);
  assign wr_slot  = wr_idx_i[SLOT_W-1:0];
  assign commit_o = wr_en_i && (wr_idx_i == WR_LAST);

  // Shadow bank: filled bin by bin as the transform unloads.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LEDS; i++) shadow_q[i] <= '0;
    end else if (wr_hit) begin
      shadow_q[wr_slot] <= wr_mag_i;
    end
  end

  // Display bank: swapped in as a whole when the last bin lands.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LEDS; i++) disp_q[i] <= '0;
    end else if (commit_o) begin
      for (int i = 0; i < N_LEDS; i++) begin
        disp_q[i] <= (i == N_LEDS - 1) ? wr_mag_i : shadow_q[i];
      end
    end
  end

  assign rd_mag_o = (rd_idx_i <= RD_LAST) ? disp_q[rd_idx_i[SLOT_W-1:0]] : '0;

endmodule

// File: rtl/spec_hue_rom.sv
module spec_hue_rom
  import spec_led_pkg::*;
#(
  parameter int N_LEDS    = 30,
  parameter int LED_IDX_W = 5
) (
  input  logic [LED_IDX_W-1:0] idx_i,
  output grb_t                 hue_o,
  output logic                 in_range_o
);

  localparam int                   SLOT_W = $clog2(N_LEDS);
  localparam logic [LED_IDX_W-1:0] LAST   = LED_IDX_W'(N_LEDS - 1);

  grb_t tbl [N_LEDS];

  for (genvar n = 0; n < N_LEDS; n++) begin : g_hue
    localparam grb_t HUE = hue_at(n, N_LEDS);
    assign tbl[n] = HUE;
  end

  assign in_range_o = (idx_i <= LAST);
  assign hue_o      = in_range_o ? tbl[idx_i[SLOT_W-1:0]] : '0;

endmodule

// File: rtl/spec_pixel_scale.sv
module spec_pixel_scale
  import spec_led_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int GAIN_W = 3
) (
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  show_mode_e        mode_i,
  input  grb_t              hue_i,
  input  logic              in_range_i,
  output grb_t              px_o
);

  localparam int                SH_W = MAG_W + (1 << GAIN_W) - 1;
  localparam logic [SH_W-1:0]   SAT  = SH_W'((1 << COMP_W) - 1);

  logic [SH_W-1:0]   shifted;
  logic [COMP_W-1:0] level;
  grb_t              dimmed;

  function automatic logic [COMP_W-1:0] dim(input logic [COMP_W-1:0] c,
                                            input logic [COMP_W-1:0] lv);
    logic [2*COMP_W:0] prod;
    prod = (2*COMP_W+1)'(c) * ((2*COMP_W+1)'(lv) + 1'b1);
    return prod[2*COMP_W-1:COMP_W];
  endfunction

  assign shifted = SH_W'(mag_i) << gain_i;
  assign level   = (shifted > SAT) ? '1 : shifted[COMP_W-1:0];

  assign dimmed.g = dim(hue_i.g, level);
  assign dimmed.r = dim(hue_i.r, level);
  assign dimmed.b = dim(hue_i.b, level);

  always_comb begin
    px_o = '0;
    if (in_range_i) begin
      unique case (mode_i)
        MODE_SPECTRUM:                px_o = dimmed;
        MODE_RAINBOW0, MODE_RAINBOW1: px_o = hue_i;
        MODE_SOLID: begin
          px_o.g = '1;
          px_o.r = '1;
          px_o.b = '0;
        end
        default:                      px_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/spec_led_mapper.sv
module spec_led_mapper
  import spec_led_pkg::*;
#(
  parameter int N_LEDS    = 30,
  parameter int MAG_W     = 8,
  parameter int IDX_W     = 10,
  parameter int GAIN_W    = 3,
  parameter int LED_IDX_W = $clog2(N_LEDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bin_valid_i,
  output logic                 bin_ready_o,
  input  logic [IDX_W-1:0]     bin_idx_i,
  input  logic [MAG_W-1:0]     bin_mag_i,
  input  logic [GAIN_W-1:0]    gain_i,
  input  logic [1:0]           mode_i,
  input  logic [LED_IDX_W-1:0] led_idx_i,
  output logic [3*COMP_W-1:0]  led_color_o
);

  logic [MAG_W-1:0] rd_mag;
  logic             store_commit;
  grb_t             hue;
  logic             in_range;
  grb_t             px;
  grb_t             color_q;

  assign bin_ready_o = 1'b1;

  spec_bin_store #(
    .N_LEDS(N_LEDS), .MAG_W(MAG_W), .IDX_W(IDX_W), .LED_IDX_W(LED_IDX_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (bin_valid_i && bin_ready_o),
    .wr_idx_i (bin_idx_i),
    .wr_mag_i (bin_mag_i),
    .rd_idx_i (led_idx_i),
    .rd_mag_o (rd_mag),
    .commit_o (store_commit)
  );

  spec_hue_rom #(
    .N_LEDS(N_LEDS), .LED_IDX_W(LED_IDX_W)
  ) u_hue (
    .idx_i      (led_idx_i),
    .hue_o      (hue),
    .in_range_o (in_range)
  );

  spec_pixel_scale #(
    .MAG_W(MAG_W), .GAIN_W(GAIN_W)
  ) u_scale (
    .mag_i      (rd_mag),
    .gain_i     (gain_i),
    .mode_i     (show_mode_e'(mode_i)),
    .hue_i      (hue),
    .in_range_i (in_range),
    .px_o       (px)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) color_q <= '0;
    else         color_q <= px;
  end

  assign led_color_o = color_q;

endmodule

// File: rtl/spec_led_mapper_chk.sv
module spec_led_mapper_chk #(
  parameter int N_LEDS    = 30,
  parameter int IDX_W     = 10,
  parameter int GAIN_W    = 3,
  parameter int LED_IDX_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bin_ready_o,
  input logic                 store_commit,
  input logic [GAIN_W-1:0]    gain_i,
  input logic [1:0]           mode_i,
  input logic [LED_IDX_W-1:0] led_idx_i,
  input logic [23:0]          led_color_o
);

  localparam logic [LED_IDX_W-1:0] LAST = LED_IDX_W'(N_LEDS - 1);

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R10: output cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_dark_r10: assert (led_color_o == '0);
  end

  p_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd1) |-> bin_ready_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm_q >= 2'd2) && !$past(store_commit, 2)
     && ($past(led_idx_i) == $past(led_idx_i, 2))
     && ($past(mode_i) == $past(mode_i, 2))
     && ($past(gain_i) == $past(gain_i, 2)))
    |-> $stable(led_color_o));

  p_rainbow_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm_q >= 2'd2) && $past(mode_i == 2'b01 || mode_i == 2'b10)
     && $past(led_idx_i <= LAST))
    |-> (led_color_o[23:16] == 8'hFF || led_color_o[15:8] == 8'hFF
         || led_color_o[7:0] == 8'hFF));

  p_yellow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm_q >= 2'd2) && $past(mode_i == 2'b11) && $past(led_idx_i <= LAST))
    |-> (led_color_o == 24'hFFFF00));

  p_oob_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((warm_q >= 2'd2) && $past(led_idx_i > LAST)) |-> (led_color_o == '0));

endmodule

bind spec_led_mapper spec_led_mapper_chk #(
  .N_LEDS(N_LEDS), .IDX_W(IDX_W), .GAIN_W(GAIN_W), .LED_IDX_W(LED_IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bin_ready_o  (bin_ready_o),
  .store_commit (store_commit),
  .gain_i       (gain_i),
  .mode_i       (mode_i),
  .led_idx_i    (led_idx_i),
  .led_color_o  (led_color_o)
);

// File: tb/spec_led_mapper_tb.sv
module spec_led_mapper_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bin_valid = 1'b0;
  logic       bin_ready;
  logic [9:0] bin_idx = '0;
  logic [7:0] bin_mag = '0;
  logic [2:0] gain = '0;
  logic [1:0] mode = '0;
  logic [4:0] led_idx = '0;
  logic [23:0] led_color;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int shadow_m [30];
  int disp_m   [30];

  always #5 clk = ~clk;

  spec_led_mapper dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bin_valid_i (bin_valid),
    .bin_ready_o (bin_ready),
    .bin_idx_i   (bin_idx),
    .bin_mag_i   (bin_mag),
    .gain_i      (gain),
    .mode_i      (mode),
    .led_idx_i   (led_idx),
    .led_color_o (led_color)
  );

  function automatic logic [23:0] hue_exp(input int n);
    int p = (n * 1275) / 29;
    int s = p / 255;
    int t = p % 255;
    int r, g, b;
    case (s)
      0: begin r = 255;     g = t;       b = 0;   end
      1: begin r = 255 - t; g = 255;     b = 0;   end
      2: begin r = 0;       g = 255;     b = t;   end
      3: begin r = 0;       g = 255 - t; b = 255; end
      4: begin r = t / 2;   g = 0;       b = 255; end
      default: begin r = 127; g = 0;     b = 255; end
    endcase
    return {g[7:0], r[7:0], b[7:0]};
  endfunction

  function automatic logic [23:0] color_exp(input int n, input int md, input int gn);
    logic [23:0] h;
    int lv, g, r, b;
    if (n >= 30) return 24'h0;
    h = hue_exp(n);
    if (md == 3) return 24'hFFFF00;
    if (md != 0) return h;
    lv = disp_m[n] << gn;
    if (lv > 255) lv = 255;
    g = (int'(h[23:16]) * (lv + 1)) >> 8;
    r = (int'(h[15:8])  * (lv + 1)) >> 8;
    b = (int'(h[7:0])   * (lv + 1)) >> 8;
    return {g[7:0], r[7:0], b[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one transfer at a falling edge; the model follows after the edge.
  task automatic put_bin(input int idx, input int mag);
    bin_valid = 1'b1;
    bin_idx   = 10'(idx);
    bin_mag   = 8'(mag);
    @(negedge clk);
    bin_valid = 1'b0;
    if (idx < 30) shadow_m[idx] = mag;
    if (idx == 29) for (int i = 0; i < 30; i++) disp_m[i] = shadow_m[i];
  endtask

  task automatic look(input int n, input int md, input int gn, input string tag);
    logic [23:0] e;
    led_idx = 5'(n);
    mode    = 2'(md);
    gain    = 3'(gn);
    @(negedge clk);
    e = color_exp(n, md, gn);
    check(led_color == e, tag, led_color, e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1337));
    for (int i = 0; i < 30; i++) begin shadow_m[i] = 0; disp_m[i] = 0; end

    // R10: reset state
    repeat (3) @(negedge clk);
    check(led_color == 24'h0, "R10 color in reset", led_color, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bin_ready == 1'b1, "R1 ready", {23'h0, bin_ready}, 24'h1);
    for (int n = 0; n < 30; n++) look(n, 0, 7, "R10 banks clear");

    // R4 / R7 / R8 / R9 directed hue and mode corners
    look(0, 1, 0, "R4 LED0 red");
    check(led_color == 24'h00FF00, "R4 red value", led_color, 24'h00FF00);
    look(29, 2, 5, "R4 LED29 violet");
    check(led_color == 24'h007FFF, "R4 violet value", led_color, 24'h007FFF);
    for (int n = 0; n < 30; n++) look(n, 1 + (n % 2), n % 8, "R7 rainbow");
    look(13, 3, 0, "R8 yellow");
    look(30, 3, 0, "R9 idx30 yellow");
    look(31, 1, 0, "R9 idx31 rainbow");
    look(31, 0, 7, "R9 idx31 spectrum");

    // R5 / R6 saturation corners
    for (int n = 0; n < 29; n++) put_bin(n, (n == 0) ? 255 : (n == 1) ? 1 : (n == 2) ? 0 : 32);
    put_bin(29, 128);
    look(0, 0, 7, "R5 mag255 gain7 saturates");
    look(0, 0, 0, "R6 mag255 full hue");
    look(1, 0, 7, "R5 mag1 gain7");
    look(1, 0, 0, "R6 mag1 gain0");
    look(2, 0, 7, "R6 zero mag black");
    look(3, 0, 3, "R5 mag32 gain3 at edge");
    look(3, 0, 4, "R5 mag32 gain4 over");
    look(29, 0, 1, "R5 mag128 gain1");
    look(29, 0, 0, "R6 mag128 gain0");

    // R1 stray high indices ignored, R2 no half frame
    put_bin(30, 7);
    put_bin(1023, 9);
    put_bin(543, 3);
    for (int n = 0; n < 29; n++) put_bin(n, 255 - n);
    for (int n = 0; n < 30; n++) look(n, 0, 0, "R2 old frame held");
    put_bin(29, 77);
    for (int n = 0; n < 30; n++) look(n, 0, 0, "R2 new frame shown");
    for (int n = 0; n < 30; n++) look(n, 0, 2, "R1 stray writes ignored");

    // R3: index changes every cycle, each result one cycle later
    for (int k = 0; k < 64; k++) look(k % 32, k % 4, (k * 3) % 8, "R3 back-to-back reads");

    // Random frames with stray transfers and idle gaps
    for (int f = 0; f < 6; f++) begin
      for (int n = 0; n < 30; n++) begin
        if ($urandom_range(3, 0) == 0) put_bin($urandom_range(1023, 30), $urandom_range(255, 0));
        if ($urandom_range(4, 0) == 0) @(negedge clk);
        put_bin(n, $urandom_range(255, 0));
        if (n == 15) look($urandom_range(29, 0), 0, $urandom_range(7, 0), "R2 mid-frame read");
      end
      for (int k = 0; k < 40; k++)
        look($urandom_range(31, 0), $urandom_range(3, 0), $urandom_range(7, 0), "R6 random read");
    end

    finish_run();
  end

endmodule